// File: doc/BRIEF.md
# Outer Cache Enable Sequencer

This block runs the bring-up of an outer cache level. The outer cache may be switched on only while both inner caches (instruction and data) are off. The block therefore tears the inner caches down in a fixed order, sets the outer-cache enable, and then turns the inner caches back on. Before any of that it makes sure outer-cache prefetch is disabled.

The block does not hold the registers it works on. It reads the current control register (inner cache enables) and feature register (outer enable, prefetch disable) from inputs. It changes them through read-modify-write strobes, so every bit it does not own passes through unchanged. The inner data-cache flush and the instruction-cache invalidate are done elsewhere. They are reached through request/acknowledge pairs. A single-cycle `start_i` launches a run, and `done_o` pulses once when the run ends.

Top module: `ocs_top`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, both requests, both write strobes and `irq_mask_o` are low until a start is accepted.
- R2: A run first sets feature bit 24 (prefetch disable). It writes the feature register only if that bit was clear, and every feature write keeps bit 24 set.
- R3: If feature bit 22 (outer enable) is already set when the prefetch step ends, the run writes no control bits, raises no request and goes straight to `done_o`.
- R4: If control bit 2 (data-cache enable) is set, a flush is requested and then bit 2 is cleared. This happens only after the flush acknowledge, and before any instruction-cache action.
- R5: `flush_req_o` and `inv_req_o` each stay high from when they rise until the cycle their acknowledge is seen. At most one of them is high at a time.
- R6: If control bit 12 (instruction-cache enable) is set, it is cleared first, and only then is an invalidate requested.
- R7: Feature bit 22 is written to one only while control bits 2 and 12 both read zero.
- R8: After the outer enable write, bit 12 is set, and then bit 2 is set. Each write is issued only if its bit reads zero, so a run that enables the outer cache ends with both inner caches on.
- R9: `irq_mask_o` is high for every cycle from the flush request through the cycle that clears bit 2, and is low at all other times.
- R10: `done_o` is a one-cycle pulse per run. A `start_i` pulse during a run is ignored.
- R11: A data cache that is off is neither flushed nor disabled. An instruction cache that is off is neither disabled nor invalidated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a run when idle |
| ctrl_i | input | REG_W | Current control register value |
| ctrl_we_o | output | 1 | Control register write strobe |
| ctrl_wdata_o | output | REG_W | Control register write data |
| feat_i | input | REG_W | Current feature register value |
| feat_we_o | output | 1 | Feature register write strobe |
| feat_wdata_o | output | REG_W | Feature register write data |
| flush_req_o | output | 1 | Inner data-cache flush request |
| flush_ack_i | input | 1 | Flush completion |
| inv_req_o | output | 1 | Instruction-cache invalidate request |
| inv_ack_i | input | 1 | Invalidate completion |
| irq_mask_o | output | 1 | Interrupts masked during flush-and-disable |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions assume three things. The register inputs show a write one cycle after its strobe. An acknowledge arrives only while its request is high. Nothing but this block writes either register during a run. The bench meets all three: it models both registers as flops loaded from the write strobes. Its responders raise an acknowledge only on a cycle where they see the request, after a programmed delay. It preloads register values only while the block is idle.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PF, S_OC_CHK, S_DC_CHK, S_DC_FL, S_DC_OFF,
    S_IC_CHK, S_IC_INV, S_OC_SET, S_IC_ON, S_DC_ON, S_FIN
  } ocs_state_e;
  localparam int unsigned CH_FLUSH = 0;
  localparam int unsigned CH_INV   = 1;
  localparam int unsigned N_CH     = 2;
endpackage

// File: rtl/ocs_hs.sv
module ocs_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic ack_i,
  output logic req_o,
  output logic fin_o
);
  assign req_o = act_i;
  assign fin_o = act_i & ack_i;

  // R5: request holds until acknowledged
  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o);
endmodule

// File: rtl/ocs_ctl.sv
module ocs_ctl import ocs_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            dc_on_i,
  input  logic            ic_on_i,
  input  logic            oc_on_i,
  input  logic [N_CH-1:0] hs_fin_i,
  output ocs_state_e      state_o
);
  ocs_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:   if (start_i) st_d = S_PF;
      S_PF:     st_d = S_OC_CHK;
      S_OC_CHK: st_d = oc_on_i ? S_FIN : S_DC_CHK;
      S_DC_CHK: st_d = dc_on_i ? S_DC_FL : S_IC_CHK;
      S_DC_FL:  if (hs_fin_i[CH_FLUSH]) st_d = S_DC_OFF;
      S_DC_OFF: st_d = S_IC_CHK;
      S_IC_CHK: st_d = ic_on_i ? S_IC_INV : S_OC_SET;
      S_IC_INV: if (hs_fin_i[CH_INV]) st_d = S_OC_SET;
      S_OC_SET: st_d = S_IC_ON;
      S_IC_ON:  st_d = S_DC_ON;
      S_DC_ON:  st_d = S_FIN;
      S_FIN:    st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;

  assign state_o = st_q;

  // R10: a start mid-run does not restart the sequence
  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && st_q != S_IDLE && st_q != S_FIN |=> st_q != S_PF);
endmodule

// File: rtl/ocs_wr.sv
module ocs_wr import ocs_pkg::*; #(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned DC_BIT = 2,
  parameter int unsigned IC_BIT = 12,
  parameter int unsigned PF_BIT = 24,
  parameter int unsigned OC_BIT = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ocs_state_e       state_i,
  input  logic [REG_W-1:0] ctrl_i,
  input  logic [REG_W-1:0] feat_i,
  output logic             ctrl_we_o,
  output logic [REG_W-1:0] ctrl_wdata_o,
  output logic             feat_we_o,
  output logic [REG_W-1:0] feat_wdata_o
);
  localparam logic [REG_W-1:0] ONE  = {{(REG_W-1){1'b0}}, 1'b1};
  localparam logic [REG_W-1:0] DC_M = ONE << DC_BIT;
  localparam logic [REG_W-1:0] IC_M = ONE << IC_BIT;
  localparam logic [REG_W-1:0] PF_M = ONE << PF_BIT;
  localparam logic [REG_W-1:0] OC_M = ONE << OC_BIT;

  always_comb begin
    ctrl_we_o    = 1'b0;
    ctrl_wdata_o = ctrl_i;
    feat_we_o    = 1'b0;
    feat_wdata_o = feat_i;
    unique case (state_i)
      S_PF: begin
        feat_we_o    = ~feat_i[PF_BIT];
        feat_wdata_o = feat_i | PF_M;
      end
      S_DC_OFF: begin
        ctrl_we_o    = 1'b1;
        ctrl_wdata_o = ctrl_i & ~DC_M;
      end
      S_IC_CHK: begin
        ctrl_we_o    = ctrl_i[IC_BIT];
        ctrl_wdata_o = ctrl_i & ~IC_M;
      end
      S_OC_SET: begin
        feat_we_o    = 1'b1;
        feat_wdata_o = feat_i | OC_M;
      end
      S_IC_ON: begin
        ctrl_we_o    = ~ctrl_i[IC_BIT];
        ctrl_wdata_o = ctrl_i | IC_M;
      end
      S_DC_ON: begin
        ctrl_we_o    = ~ctrl_i[DC_BIT];
        ctrl_wdata_o = ctrl_i | DC_M;
      end
      default: ;
    endcase
  end

  // R2: every feature write carries prefetch disable
  p_pf_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feat_we_o |-> feat_wdata_o[PF_BIT]);
  // R7: outer enable only with both inner caches off
  p_oc_guard_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feat_we_o && feat_wdata_o[OC_BIT] && !feat_i[OC_BIT] |-> !ctrl_i[DC_BIT] && !ctrl_i[IC_BIT]);
endmodule

// File: rtl/ocs_top.sv
module ocs_top import ocs_pkg::*; #(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned DC_BIT = 2,
  parameter int unsigned IC_BIT = 12,
  parameter int unsigned PF_BIT = 24,
  parameter int unsigned OC_BIT = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [REG_W-1:0] ctrl_i,
  output logic             ctrl_we_o,
  output logic [REG_W-1:0] ctrl_wdata_o,
  input  logic [REG_W-1:0] feat_i,
  output logic             feat_we_o,
  output logic [REG_W-1:0] feat_wdata_o,
  output logic             flush_req_o,
  input  logic             flush_ack_i,
  output logic             inv_req_o,
  input  logic             inv_ack_i,
  output logic             irq_mask_o,
  output logic             done_o
);
  ocs_state_e      state;
  logic [N_CH-1:0] hs_act, hs_ack, hs_req, hs_fin;

  ocs_ctl u_ctl (
    .clk_i, .rst_ni, .start_i,
    .dc_on_i  (ctrl_i[DC_BIT]),
    .ic_on_i  (ctrl_i[IC_BIT]),
    .oc_on_i  (feat_i[OC_BIT]),
    .hs_fin_i (hs_fin),
    .state_o  (state)
  );

  ocs_wr #(
    .REG_W(REG_W), .DC_BIT(DC_BIT), .IC_BIT(IC_BIT), .PF_BIT(PF_BIT), .OC_BIT(OC_BIT)
  ) u_wr (
    .clk_i, .rst_ni,
    .state_i (state),
    .ctrl_i, .feat_i,
    .ctrl_we_o, .ctrl_wdata_o, .feat_we_o, .feat_wdata_o
  );

  assign hs_act[CH_FLUSH] = (state == S_DC_FL);
  assign hs_act[CH_INV]   = (state == S_IC_INV);
  assign hs_ack[CH_FLUSH] = flush_ack_i;
  assign hs_ack[CH_INV]   = inv_ack_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_hs
    ocs_hs u_hs (
      .clk_i, .rst_ni,
      .act_i (hs_act[g]),
      .ack_i (hs_ack[g]),
      .req_o (hs_req[g]),
      .fin_o (hs_fin[g])
    );
  end

  assign flush_req_o = hs_req[CH_FLUSH];
  assign inv_req_o   = hs_req[CH_INV];
  assign irq_mask_o  = (state == S_DC_FL) || (state == S_DC_OFF);
  assign done_o      = (state == S_FIN);

  // R4: data cache is cleared only right after the flush acknowledge
  p_dc_off_after_flush_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_o && ctrl_i[DC_BIT] && !ctrl_wdata_o[DC_BIT] |-> $past(flush_ack_i));
  // R5: requests never overlap
  p_req_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flush_req_o && inv_req_o));
  // R6: invalidate only once the I-cache reads off
  p_inv_after_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_req_o |-> !ctrl_i[IC_BIT]);
  // R9: masking covers the flush
  p_irq_during_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> irq_mask_o);
  // R10: single-cycle done
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/ocs_top_tb.sv
module ocs_top_tb;
  localparam int unsigned W = 32;
  localparam int unsigned DCB = 2, ICB = 12, PFB = 24, OCB = 22;
  localparam logic [W-1:0] CTRL_BASE = 32'h0005_0078;
  localparam logic [W-1:0] FEAT_BASE = 32'h0000_0f05;
  // {dc, ic, pf, oc, ack_delay[3:0]}
  localparam logic [7:0] VEC [0:7] = '{
    8'b1100_0010, 8'b0000_0000, 8'b1000_0011, 8'b0100_0001,
    8'b1110_0000, 8'b1101_0001, 8'b0011_0000, 8'b1100_0101
  };

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [W-1:0] ctrl_q, feat_q, ctrl_wd, feat_wd, ctrl_init, feat_init;
  logic ctrl_we, feat_we, flush_req, inv_req, flush_ack, inv_ack, irq_mask, done;
  logic load = 1'b0, clr = 1'b0;
  int unsigned dly = 0, fcnt = 0, icnt = 0;
  int unsigned n_chk = 0, n_fail = 0, cyc = 0;
  logic [47:0] seq;
  int unsigned irq_cnt, done_cnt, evt_cnt;
  logic guard_bad, pf_prev, pi_prev;

  always #10 clk = ~clk;

  ocs_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .ctrl_i(ctrl_q), .ctrl_we_o(ctrl_we), .ctrl_wdata_o(ctrl_wd),
    .feat_i(feat_q), .feat_we_o(feat_we), .feat_wdata_o(feat_wd),
    .flush_req_o(flush_req), .flush_ack_i(flush_ack),
    .inv_req_o(inv_req), .inv_ack_i(inv_ack),
    .irq_mask_o(irq_mask), .done_o(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (load) begin
      ctrl_q <= ctrl_init;
      feat_q <= feat_init;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wd;
      if (feat_we) feat_q <= feat_wd;
    end
  end

  // responders and event monitor, away from the active edge
  always @(negedge clk) begin
    if (flush_req) begin flush_ack = (fcnt == dly); fcnt++; end
    else begin flush_ack = 1'b0; fcnt = 0; end
    if (inv_req) begin inv_ack = (icnt == dly); icnt++; end
    else begin inv_ack = 1'b0; icnt = 0; end
    if (clr) begin
      seq = '0; irq_cnt = 0; done_cnt = 0; evt_cnt = 0;
      guard_bad = 1'b0; pf_prev = 1'b0; pi_prev = 1'b0;
    end else begin
      if (feat_we && feat_wd[PFB] && !feat_q[PFB]) begin seq = (seq << 4) | 48'd1; evt_cnt++; end
      if (flush_req && !pf_prev) begin seq = (seq << 4) | 48'd2; evt_cnt++; end
      if (ctrl_we && ctrl_q[DCB] && !ctrl_wd[DCB]) begin seq = (seq << 4) | 48'd3; evt_cnt++; end
      if (ctrl_we && ctrl_q[ICB] && !ctrl_wd[ICB]) begin seq = (seq << 4) | 48'd4; evt_cnt++; end
      if (inv_req && !pi_prev) begin seq = (seq << 4) | 48'd5; evt_cnt++; end
      if (feat_we && feat_wd[OCB] && !feat_q[OCB]) begin
        seq = (seq << 4) | 48'd6; evt_cnt++;
        if (ctrl_q[DCB] || ctrl_q[ICB]) guard_bad = 1'b1;
      end
      if (ctrl_we && !ctrl_q[ICB] && ctrl_wd[ICB]) begin seq = (seq << 4) | 48'd7; evt_cnt++; end
      if (ctrl_we && !ctrl_q[DCB] && ctrl_wd[DCB]) begin seq = (seq << 4) | 48'd8; evt_cnt++; end
      pf_prev = flush_req;
      pi_prev = inv_req;
      if (irq_mask) irq_cnt++;
      if (done) done_cnt++;
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_seq(input logic dc, ic, pf, oc);
    logic [47:0] s = '0;
    if (!pf) s = (s << 4) | 48'd1;
    if (!oc) begin
      if (dc) s = (s << 8) | 48'h23;
      if (ic) s = (s << 8) | 48'h45;
      s = (s << 12) | 48'h678;
    end
    return s;
  endfunction

  task automatic run_case(input logic [7:0] v, input bit inject);
    logic dc = v[7], ic = v[6], pf = v[5], oc = v[4];
    logic [W-1:0] ec, ef;
    @(negedge clk);
    dly = v[3:0];
    ctrl_init = CTRL_BASE | (W'(dc) << DCB) | (W'(ic) << ICB);
    feat_init = FEAT_BASE | (W'(pf) << PFB) | (W'(oc) << OCB);
    load = 1'b1; clr = 1'b1;
    @(negedge clk);
    load = 1'b0; clr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 300 && done_cnt == 0; i++) begin
      if (inject && i == 3) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    repeat (6) @(negedge clk);
    ec = oc ? ctrl_init : (CTRL_BASE | (W'(1) << DCB) | (W'(1) << ICB));
    ef = FEAT_BASE | (W'(1) << PFB) | (W'(1) << OCB);
    // R2 R3 R4 R6 R8 R11: event order
    chk("R4 R6 R8 R11 order", 64'(seq), 64'(exp_seq(dc, ic, pf, oc)));
    chk("R8 ctrl final", 64'(ctrl_q), 64'(ec));
    chk("R2 feat final", 64'(feat_q), 64'(ef));
    chk("R10 done pulses", 64'(done_cnt), 64'd1);
    chk("R9 irq cycles", 64'(irq_cnt), (dc && !oc) ? 64'(dly + 2) : 64'd0);
    chk("R7 guard", 64'(guard_bad), 64'd0);
  endtask

  initial begin
    ctrl_init = CTRL_BASE; feat_init = FEAT_BASE;
    ctrl_q = CTRL_BASE; feat_q = FEAT_BASE;
    flush_ack = 1'b0; inv_ack = 1'b0;
    clr = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet in reset
    chk("R1 reset outputs", 64'({done, flush_req, inv_req, ctrl_we, feat_we, irq_mask}), 64'd0);
    rst_ni = 1'b1;
    clr = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 idle outputs", 64'({done, flush_req, inv_req, ctrl_we, feat_we, irq_mask}), 64'd0);
    chk("R1 no events", 64'(evt_cnt), 64'd0);

    for (int k = 0; k < 8; k++) run_case(VEC[k], 1'b0);

    // R10: start pulse mid-run ignored
    run_case(8'b1100_0011, 1'b1);
    // R3: outer already enabled, no requests, ctrl untouched
    run_case(8'b1111_0000, 1'b1);

    // R1: reset during a pending flush
    @(negedge clk);
    dly = 15; ctrl_init = CTRL_BASE | (W'(1) << DCB); feat_init = FEAT_BASE;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 flush held", 64'(flush_req), 64'd1);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", 64'({done, flush_req, inv_req, ctrl_we, feat_we, irq_mask}), 64'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 stays idle", 64'({flush_req, irq_mask, done}), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule